// File: doc/BRIEF.md
# Sorted Ready-Queue Scheduler with Compact Task Tags

This block holds the set of tasks that are ready to run, in ascending order of a per-task key that can be a priority or a deadline. Software names each task by its full 32-bit pointer. On the first insert, the block gives the pointer a narrow internal tag. The tag is sized by the maximum task count fixed at elaboration. The ordered list, the key comparisons and the position search all work on these narrow tags and keys, never on full pointers. One shared key comparator and one shared pointer comparator are stepped through the entries one per cycle. There is no row of parallel comparators.

Commands enter over a valid/ready channel. `cmd_ready` is high only while the block is idle. A command is taken on the rising edge where `cmd_valid` and `cmd_ready` are both high. While `cmd_ready` is low, the source must hold `cmd_valid` and the command fields steady. Each command ends with a one-cycle `rsp_valid` pulse that carries an error flag. The task at the front of the queue is always shown on `head_ptr` and `head_key`, qualified by `head_valid`.

Top module: `rq_sched`

## Requirements
- R1: `cmd_ready` is high only when idle. `busy` is its inverse. A command is accepted when `cmd_valid` and `cmd_ready` are both high at a rising edge. `cmd_ready` is low in the following cycle.
- R2: Every accepted command produces exactly one `rsp_valid` pulse, one cycle long, while `cmd_ready` is low. `cmd_ready` returns high in the next cycle.
- R3: After reset, and whenever no task is queued, `head_valid` is 0. It is 1 whenever at least one task is queued. The head outputs do not change while the block is idle and receives no command.
- R4: `head_ptr`/`head_key` show the queued task with the smallest unsigned key. Among equal keys, the task that entered the queue earliest comes first.
- R5: `cmd_op`=0 (insert) of a pointer that is already mapped reports `rsp_err`=1 and changes nothing.
- R6: Insert of a new pointer while MAX_TASKS pointers are mapped reports `rsp_err`=1. Otherwise, insert maps the pointer, stores its key and queues it.
- R7: Remove, suspend or resume of a pointer that is not mapped reports `rsp_err`=1 and changes nothing.
- R8: `cmd_op`=2 (suspend) takes a queued task out of the order but keeps its mapping and key. Suspending a task that is not queued reports `rsp_err`=1.
- R9: `cmd_op`=3 (resume) puts a suspended task back into the queue with its stored key (the `cmd_key` field is ignored). It goes behind all queued tasks with an equal key. Resuming a queued task reports `rsp_err`=1.
- R10: `cmd_op`=1 (remove) takes the task out of the queue if it is there and releases its tag. This works for queued and for suspended tasks. A released tag can be reused by a later insert.
- R11: `cmd_ready` never stays low for more than 2*MAX_TASKS+2 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_op | input | 2 | 0 insert, 1 remove, 2 suspend, 3 resume |
| cmd_ptr | input | PTR_W | Task pointer |
| cmd_key | input | KEY_W | Ordering key (used by insert only) |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Command rejected; valid with rsp_valid |
| busy | output | 1 | Command in progress |
| head_valid | output | 1 | Queue not empty |
| head_ptr | output | PTR_W | Pointer of the front task |
| head_key | output | KEY_W | Key of the front task |

## Verification
A four-task build is filled with every combination of four keys drawn from four values, so that all tie patterns and all orderings appear. Each fill is then drained from the front, which shows whether the full order and the FIFO rule among equal keys hold. Directed sequences separate the error cases from one another: duplicate pointer, full map, unknown pointer, double suspend and resume of a queued task. They also test the placement of a resumed task behind its equals. A long pseudo-random mix of all four commands over a small pointer pool stresses tag reuse and the interleaving of suspended and queued tasks against an arithmetic reference model.

// File: rtl/rq_pkg.sv
package rq_pkg;

  typedef enum logic [1:0] {
    OP_INSERT  = 2'd0,
    OP_REMOVE  = 2'd1,
    OP_SUSPEND = 2'd2,
    OP_RESUME  = 2'd3
  } rq_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOK,
    S_DECIDE,
    S_FPOS,
    S_FID,
    S_DONE
  } rq_state_e;

endpackage

// File: rtl/rq_idmap.sv
// Per-tag record store: pointer, key, mapped and queued flags.
// One shared pointer read port feeds the sequential lookup.
module rq_idmap #(
  parameter int PTR_W = 32,
  parameter int KEY_W = 8,
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_used,
  input  logic             wr_queued,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [IDX_W-1:0] scan_idx,
  output logic [PTR_W-1:0] scan_ptr,
  input  logic [IDX_W-1:0] key_idx,
  output logic [KEY_W-1:0] key_val,
  input  logic [IDX_W-1:0] hd_idx,
  output logic [PTR_W-1:0] hd_ptr,
  output logic [KEY_W-1:0] hd_key,
  output logic [N-1:0]     used_v,
  output logic [N-1:0]     queued_v,
  output logic [IDX_W-1:0] free_idx,
  output logic             full
);

  logic [PTR_W-1:0] ptr_mem [N];
  logic [KEY_W-1:0] key_mem [N];

  always_ff @(posedge clk) begin
    if (we) begin
      ptr_mem[wr_idx] <= wr_ptr;
      key_mem[wr_idx] <= wr_key;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_v   <= '0;
      queued_v <= '0;
    end else if (we) begin
      used_v[wr_idx]   <= wr_used;
      queued_v[wr_idx] <= wr_queued;
    end
  end

  assign scan_ptr = ptr_mem[scan_idx];
  assign key_val  = key_mem[key_idx];
  assign hd_ptr   = ptr_mem[hd_idx];
  assign hd_key   = key_mem[hd_idx];

  // lowest unmapped tag
  always_comb begin
    free_idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (!used_v[k]) free_idx = IDX_W'(k);
    end
  end

  assign full = &used_v;

endmodule

// File: rtl/rq_order.sv
// Ordered list of tags; slot 0 is the front. Insert shifts the tail
// up from a position, delete shifts it down.
module rq_order #(
  parameter int N     = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic [CNT_W-1:0] ins_pos,
  input  logic [IDX_W-1:0] ins_id,
  input  logic             del_en,
  input  logic [CNT_W-1:0] del_pos,
  input  logic [CNT_W-1:0] rd_pos,
  output logic [IDX_W-1:0] rd_id,
  output logic [IDX_W-1:0] head_id,
  output logic [CNT_W-1:0] count
);

  logic [IDX_W-1:0] slot  [N];
  logic [IDX_W-1:0] sh_up [N];
  logic [IDX_W-1:0] sh_dn [N];

  for (genvar g = 0; g < N; g++) begin : g_shift
    if (g == 0) begin : g_first
      assign sh_up[g] = slot[g];
    end else begin : g_rest
      assign sh_up[g] = slot[g-1];
    end
    if (g == N - 1) begin : g_last
      assign sh_dn[g] = slot[g];
    end else begin : g_inner
      assign sh_dn[g] = slot[g+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) slot[k] <= '0;
      count <= '0;
    end else if (ins_en) begin
      for (int k = 0; k < N; k++) begin
        if (CNT_W'(k) == ins_pos)     slot[k] <= ins_id;
        else if (CNT_W'(k) > ins_pos) slot[k] <= sh_up[k];
      end
      count <= count + CNT_W'(1);
    end else if (del_en) begin
      for (int k = 0; k < N; k++) begin
        if (CNT_W'(k) >= del_pos) slot[k] <= sh_dn[k];
      end
      count <= count - CNT_W'(1);
    end
  end

  assign rd_id   = (rd_pos < CNT_W'(N)) ? slot[rd_pos[IDX_W-1:0]] : '0;
  assign head_id = slot[0];

endmodule

// File: rtl/rq_sched.sv
module rq_sched
  import rq_pkg::*;
#(
  parameter int PTR_W     = 32,
  parameter int MAX_TASKS = 8,
  parameter int KEY_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [PTR_W-1:0] cmd_ptr,
  input  logic [KEY_W-1:0] cmd_key,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic             busy,
  output logic             head_valid,
  output logic [PTR_W-1:0] head_ptr,
  output logic [KEY_W-1:0] head_key
);

  localparam int IDX_W = (MAX_TASKS > 1) ? $clog2(MAX_TASKS) : 1;
  localparam int CNT_W = $clog2(MAX_TASKS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAX_TASKS - 1);

  rq_state_e        st;
  rq_op_e           op_q;
  logic [PTR_W-1:0] ptr_q;
  logic [KEY_W-1:0] key_q;
  logic [IDX_W-1:0] scan_i;
  logic [IDX_W-1:0] hid_q;
  logic [CNT_W-1:0] pos_q;
  logic             hit_q;
  logic             err_q;

  // record store interface
  logic             map_we;
  logic [IDX_W-1:0] map_idx;
  logic             map_used;
  logic             map_queued;
  logic [PTR_W-1:0] map_ptr;
  logic [KEY_W-1:0] map_key;
  logic [PTR_W-1:0] scan_ptr;
  logic [IDX_W-1:0] key_idx;
  logic [KEY_W-1:0] key_val;
  logic [PTR_W-1:0] hd_ptr;
  logic [KEY_W-1:0] hd_key;
  logic [MAX_TASKS-1:0] used_v;
  logic [MAX_TASKS-1:0] queued_v;
  logic [IDX_W-1:0] free_idx;
  logic             full;

  // order list interface
  logic             ins_en;
  logic             del_en;
  logic [IDX_W-1:0] ord_rd_id;
  logic [IDX_W-1:0] ord_head;
  logic [CNT_W-1:0] ord_cnt;

  logic             scan_hit;
  logic             place_here;
  logic             id_here;

  rq_idmap #(
    .PTR_W(PTR_W), .KEY_W(KEY_W), .N(MAX_TASKS), .IDX_W(IDX_W)
  ) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (map_we),
    .wr_idx   (map_idx),
    .wr_used  (map_used),
    .wr_queued(map_queued),
    .wr_ptr   (map_ptr),
    .wr_key   (map_key),
    .scan_idx (scan_i),
    .scan_ptr (scan_ptr),
    .key_idx  (key_idx),
    .key_val  (key_val),
    .hd_idx   (ord_head),
    .hd_ptr   (hd_ptr),
    .hd_key   (hd_key),
    .used_v   (used_v),
    .queued_v (queued_v),
    .free_idx (free_idx),
    .full     (full)
  );

  rq_order #(
    .N(MAX_TASKS), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_ord (
    .clk    (clk),
    .rst_n  (rst_n),
    .ins_en (ins_en),
    .ins_pos(pos_q),
    .ins_id (hid_q),
    .del_en (del_en),
    .del_pos(pos_q),
    .rd_pos (pos_q),
    .rd_id  (ord_rd_id),
    .head_id(ord_head),
    .count  (ord_cnt)
  );

  // shared comparators: one pointer compare, one key compare, one tag compare
  assign scan_hit   = used_v[scan_i] && (scan_ptr == ptr_q);
  assign key_idx    = (st == S_FPOS) ? ord_rd_id : hid_q;
  assign place_here = (pos_q == ord_cnt) || (key_val > key_q);
  assign id_here    = (pos_q < ord_cnt) && (ord_rd_id == hid_q);

  always_comb begin
    map_we     = 1'b0;
    map_idx    = hid_q;
    map_used   = 1'b0;
    map_queued = 1'b0;
    map_ptr    = ptr_q;
    map_key    = key_q;
    ins_en     = 1'b0;
    del_en     = 1'b0;
    unique case (st)
      S_DECIDE: begin
        if (op_q == OP_INSERT && !hit_q && !full) begin
          map_we   = 1'b1;
          map_idx  = free_idx;
          map_used = 1'b1;
        end else if (op_q == OP_REMOVE && hit_q && !queued_v[hid_q]) begin
          map_we = 1'b1;
        end
      end
      S_FPOS: begin
        if (place_here) begin
          ins_en     = 1'b1;
          map_we     = 1'b1;
          map_used   = 1'b1;
          map_queued = 1'b1;
        end
      end
      S_FID: begin
        if (id_here) begin
          del_en   = 1'b1;
          map_we   = 1'b1;
          map_used = (op_q != OP_REMOVE);
          map_key  = key_val;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= OP_INSERT;
      ptr_q  <= '0;
      key_q  <= '0;
      scan_i <= '0;
      hid_q  <= '0;
      pos_q  <= '0;
      hit_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (cmd_valid) begin
            op_q   <= rq_op_e'(cmd_op);
            ptr_q  <= cmd_ptr;
            key_q  <= cmd_key;
            scan_i <= '0;
            err_q  <= 1'b0;
            st     <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (scan_hit) begin
            hit_q <= 1'b1;
            hid_q <= scan_i;
            st    <= S_DECIDE;
          end else if (scan_i == LAST_IDX) begin
            hit_q <= 1'b0;
            st    <= S_DECIDE;
          end else begin
            scan_i <= scan_i + IDX_W'(1);
          end
        end
        S_DECIDE: begin
          pos_q <= '0;
          unique case (op_q)
            OP_INSERT: begin
              if (hit_q || full) begin
                err_q <= 1'b1;
                st    <= S_DONE;
              end else begin
                hid_q <= free_idx;
                st    <= S_FPOS;
              end
            end
            OP_REMOVE: begin
              if (!hit_q) begin
                err_q <= 1'b1;
                st    <= S_DONE;
              end else if (queued_v[hid_q]) begin
                st <= S_FID;
              end else begin
                st <= S_DONE;
              end
            end
            OP_SUSPEND: begin
              if (!hit_q || !queued_v[hid_q]) begin
                err_q <= 1'b1;
                st    <= S_DONE;
              end else begin
                st <= S_FID;
              end
            end
            OP_RESUME: begin
              if (!hit_q || queued_v[hid_q]) begin
                err_q <= 1'b1;
                st    <= S_DONE;
              end else begin
                key_q <= key_val;
                st    <= S_FPOS;
              end
            end
            default: st <= S_DONE;
          endcase
        end
        S_FPOS: begin
          if (place_here) st <= S_DONE;
          else            pos_q <= pos_q + CNT_W'(1);
        end
        S_FID: begin
          if (id_here) begin
            st <= S_DONE;
          end else if (pos_q >= ord_cnt) begin
            err_q <= 1'b1;
            st    <= S_DONE;
          end else begin
            pos_q <= pos_q + CNT_W'(1);
          end
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready  = (st == S_IDLE);
  assign busy       = ~cmd_ready;
  assign rsp_valid  = (st == S_DONE);
  assign rsp_err    = rsp_valid & err_q;
  assign head_valid = (ord_cnt != '0);
  assign head_ptr   = hd_ptr;
  assign head_key   = hd_key;

endmodule

// File: rtl/rq_sched_chk.sv
module rq_sched_chk #(
  parameter int PTR_W     = 32,
  parameter int MAX_TASKS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             rsp_valid,
  input logic             head_valid,
  input logic [PTR_W-1:0] head_ptr
);

  localparam int LIMIT = 2 * MAX_TASKS + 2;
  localparam int RUN_W = $clog2(LIMIT + 2);

  logic [RUN_W-1:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy_run <= '0;
    else if (cmd_ready)  busy_run <= '0;
    else if (busy_run < RUN_W'(LIMIT + 1)) busy_run <= busy_run + RUN_W'(1);
  end

  p_accept_leaves_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  p_rsp_inside_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);

  p_rsp_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && cmd_ready));

  p_head_quiet_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && !cmd_valid) |=> ($stable(head_valid) && $stable(head_ptr)));

  p_busy_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |-> (busy_run < RUN_W'(LIMIT)));

endmodule

bind rq_sched rq_sched_chk #(.PTR_W(PTR_W), .MAX_TASKS(MAX_TASKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .rsp_valid (rsp_valid),
  .head_valid(head_valid),
  .head_ptr  (head_ptr)
);

// File: tb/tb_rq_sched.sv
module tb_rq_sched;

  localparam int NT    = 4;
  localparam int KW    = 4;
  localparam int PW    = 32;
  localparam int BOUND = 2 * NT + 2;

  localparam int OPI = 0, OPR = 1, OPS = 2, OPM = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = '0;
  logic [PW-1:0] cmd_ptr = '0;
  logic [KW-1:0] cmd_key = '0;
  logic          rsp_valid;
  logic          rsp_err;
  logic          busy;
  logic          head_valid;
  logic [PW-1:0] head_ptr;
  logic [KW-1:0] head_key;

  always #4 clk = ~clk;

  rq_sched #(.PTR_W(PW), .MAX_TASKS(NT), .KEY_W(KW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_ptr(cmd_ptr), .cmd_key(cmd_key),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .busy(busy),
    .head_valid(head_valid), .head_ptr(head_ptr), .head_key(head_key)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference model
  bit            m_used [NT];
  bit            m_q    [NT];
  logic [PW-1:0] m_ptr  [NT];
  int            m_key  [NT];
  int            m_seq  [NT];
  int            seqc = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int find(input logic [PW-1:0] p);
    for (int s = 0; s < NT; s++) if (m_used[s] && m_ptr[s] == p) return s;
    return -1;
  endfunction

  function automatic int head_slot();
    int h = -1;
    for (int s = 0; s < NT; s++) begin
      if (m_q[s]) begin
        if (h < 0 || m_key[s] < m_key[h] || (m_key[s] == m_key[h] && m_seq[s] < m_seq[h]))
          h = s;
      end
    end
    return h;
  endfunction

  task automatic model(input int op, input logic [PW-1:0] p, input int k, output bit e);
    int f = find(p);
    int fr = -1;
    e = 0;
    case (op)
      OPI: begin
        for (int s = NT - 1; s >= 0; s--) if (!m_used[s]) fr = s;
        if (f >= 0 || fr < 0) e = 1;
        else begin
          m_used[fr] = 1; m_q[fr] = 1; m_ptr[fr] = p; m_key[fr] = k; m_seq[fr] = seqc++;
        end
      end
      OPR: begin
        if (f < 0) e = 1;
        else begin m_used[f] = 0; m_q[f] = 0; end
      end
      OPS: begin
        if (f < 0 || !m_q[f]) e = 1;
        else m_q[f] = 0;
      end
      default: begin
        if (f < 0 || m_q[f]) e = 1;
        else begin m_q[f] = 1; m_seq[f] = seqc++; end
      end
    endcase
  endtask

  task automatic do_op(input int op, input logic [PW-1:0] p, input int k,
                       output bit e, output int lat);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 2'(op);
    cmd_ptr   = p;
    cmd_key   = KW'(k);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready && busy, "R1 accept drops ready", {cmd_ready, busy}, 2'b01);
    lat = 1;
    while (!rsp_valid && lat < 4 * BOUND) begin
      @(negedge clk);
      lat++;
    end
    e = rsp_err;
    @(negedge clk);
    chk(!rsp_valid && cmd_ready, "R2 single pulse then ready", {rsp_valid, cmd_ready}, 2'b01);
  endtask

  task automatic check_head();
    int h = head_slot();
    chk(head_valid == (h >= 0), "R3 head_valid", head_valid, (h >= 0));
    if (h >= 0) begin
      chk(head_ptr == m_ptr[h], "R4 head pointer", head_ptr, m_ptr[h]);
      chk(int'(head_key) == m_key[h], "R4 head key", head_key, m_key[h]);
    end
  endtask

  task automatic run(input int op, input logic [PW-1:0] p, input int k, input string tag);
    bit ee, ea;
    int lat;
    model(op, p, k, ee);
    do_op(op, p, k, ea, lat);
    chk(ea == ee, tag, ea, ee);
    chk(lat <= BOUND, "R11 busy length", lat, BOUND);
    check_head();
  endtask

  function automatic string op_tag(input int op);
    case (op)
      OPI:     return "R6 insert error flag";
      OPR:     return "R10 remove error flag";
      OPS:     return "R8 suspend error flag";
      default: return "R9 resume error flag";
    endcase
  endfunction

  initial begin
    for (int s = 0; s < NT; s++) begin
      m_used[s] = 0; m_q[s] = 0; m_ptr[s] = '0; m_key[s] = 0; m_seq[s] = 0;
    end
    repeat (3) @(negedge clk);
    chk(head_valid == 1'b0, "R3 reset head_valid", head_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1 && busy == 1'b0, "R1 reset ready", {cmd_ready, busy}, 2'b10);
    chk(rsp_valid == 1'b0, "R2 reset rsp", rsp_valid, 0);
    chk(head_valid == 1'b0, "R3 empty after reset", head_valid, 0);

    // sweep every 4-key pattern over keys 0..3, drain from the front
    for (int c = 0; c < 256; c++) begin
      for (int j = 0; j < NT; j++)
        run(OPI, 32'hA000_0000 | (c << 8) | (j << 2), (c >> (2 * j)) & 3, "R6 insert");
      if (c % 32 == 0) run(OPI, 32'hBEEF_0000 | c, 0, "R6 insert when full");
      for (int j = 0; j < NT; j++) begin
        int h = head_slot();
        run(OPR, m_ptr[h], 0, "R10 remove head");
      end
    end

    // directed corner cases
    run(OPI, 32'h1111_0000, 2, "R6 insert A");
    run(OPI, 32'h1111_0000, 1, "R5 duplicate insert");
    run(OPR, 32'h9999_0000, 0, "R7 remove unknown");
    run(OPS, 32'h9999_0000, 0, "R7 suspend unknown");
    run(OPM, 32'h9999_0000, 0, "R7 resume unknown");
    run(OPI, 32'h2222_0000, 2, "R6 insert B");
    run(OPI, 32'h3333_0000, 1, "R6 insert C");
    run(OPS, 32'h3333_0000, 0, "R8 suspend C");
    run(OPS, 32'h3333_0000, 0, "R8 suspend twice");
    run(OPM, 32'h1111_0000, 0, "R9 resume queued");
    run(OPM, 32'h3333_0000, 7, "R9 resume C with stored key");
    run(OPS, 32'h1111_0000, 0, "R8 suspend A");
    run(OPM, 32'h1111_0000, 0, "R9 resume A behind equal B");
    run(OPR, 32'h3333_0000, 0, "R10 remove C");
    run(OPR, 32'h2222_0000, 0, "R9 remove B, A follows");
    run(OPS, 32'h1111_0000, 0, "R8 suspend A again");
    run(OPR, 32'h1111_0000, 0, "R10 remove suspended A");
    run(OPM, 32'h1111_0000, 0, "R7 resume after remove");
    for (int j = 0; j < NT; j++) run(OPI, 32'h4444_0000 + j, 3 - j, "R10 tags reused");
    for (int j = 0; j < NT; j++) run(OPR, 32'h4444_0000 + j, 0, "R10 empty again");

    // pseudo-random mix over a small pointer pool
    begin
      logic [31:0] r = 32'h1234_5677;
      for (int n = 0; n < 2500; n++) begin
        int op;
        r = r ^ (r << 13);
        r = r ^ (r >> 17);
        r = r ^ (r << 5);
        op = int'(r[1:0]);
        run(op, 32'hC000_0000 + 32'(int'(r[10:2]) % 6) * 32'h40, int'(r[13:12]), op_tag(op));
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R11 actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule